// File: doc/BRIEF.md
# Fiber Auto-Negotiation Receive Status Word

This block turns the receive-side negotiation signals of a 1000BASE-X style MAC port into one 32-bit status word. Software or a register bank reads that word. The word carries three things:

- the 16-bit configuration word last received from the link partner;
- a completion flag that stays set once negotiation reaches LINK_OK;
- a synchronization flag that latches low on any loss of sync.

The negotiation state machine, ordered-set decoding and the bus interface all sit outside the block. The block only registers their results and applies the hold rules. The completion flag stays set until negotiation is restarted or disabled. The sync flag holds a loss event until someone reads the word. A read strobe marks the cycle in which the word is consumed, and the sync latch reloads from the live signal at the end of that cycle.

Top module: `an_rx_status`

## Requirements
- R1: Bits 15:0 of the status word equal the partner config word sampled at the previous rising clock edge.
- R2: When negotiation is enabled, not restarting and LINK_OK is indicated, bit 21 (complete) reads 1 from the next cycle.
- R3: Once set, bit 21 holds while enable stays high and restart stays low. A restart pulse clears it on the next cycle, and restart takes priority over LINK_OK in the same cycle.
- R4: While negotiation is disabled, bit 21 reads 0, and LINK_OK cannot set it.
- R5: Bit 20 (sync) goes to 0 the cycle after the live sync input is sampled low without a read. It then stays 0 until a read occurs, even if sync returns.
- R6: In a cycle with the read strobe high, the word shows the latched sync value. In the next cycle, bit 20 equals the live sync input sampled at that read's edge.
- R7: Bits 31:22 and 19:16 always read 0.
- R8: During reset the whole word is 0. After reset, bit 20 stays 0 until the first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word_i | input | 16 | Config word received from the link partner |
| link_ok_i | input | 1 | Negotiation has reached LINK_OK |
| an_enable_i | input | 1 | Auto-negotiation enabled |
| an_restart_i | input | 1 | Auto-negotiation restart pulse |
| sync_i | input | 1 | Live synchronization indication |
| rd_i | input | 1 | The status word is being read this cycle |
| status_o | output | 32 | Assembled status word |

## Verification
The properties check the following on every cycle:
- the config field follows its input with one cycle of delay;
- the completion flag's set, clear, hold and priority rules;
- that the sync flag never rises without a read and reloads correctly after one;
- that reserved bits stay zero.

Only the bench's scenarios show how these rules combine over longer histories. Examples are a loss of sync that recovers before a read, back-to-back reads, and completion surviving a change in the config word.

// File: rtl/an_rx_pkg.sv
package an_rx_pkg;
    localparam int unsigned AN_WORD_W   = 32;
    localparam int unsigned AN_CFG_W    = 16;
    localparam int unsigned AN_DONE_POS = 21;
    localparam int unsigned AN_SYNC_POS = 20;

    typedef struct packed {
        logic done;
        logic sync;
    } an_flags_t;
endpackage

// File: rtl/an_cfg_capture.sv
module an_cfg_capture #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/an_flag_logic.sv
module an_flag_logic
    import an_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      link_ok_i,
    input  logic      an_enable_i,
    input  logic      an_restart_i,
    input  logic      sync_i,
    input  logic      rd_i,
    output an_flags_t flags_o
);
    an_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        // completion: clear dominates, then set, else hold
        if (!an_enable_i || an_restart_i) flags_d.done = 1'b0;
        else if (link_ok_i)               flags_d.done = 1'b1;
        // sync: a read re-arms from live input, otherwise latch low
        if (rd_i) flags_d.sync = sync_i;
        else      flags_d.sync = flags_q.sync & sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/an_word_pack.sv
module an_word_pack
    import an_rx_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned CFG_W    = 16,
    parameter int unsigned DONE_POS = 21,
    parameter int unsigned SYNC_POS = 20
) (
    input  logic [CFG_W-1:0]  cfg_i,
    input  an_flags_t         flags_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o                = '0;
        word_o[CFG_W-1:0]     = cfg_i;
        word_o[DONE_POS]      = flags_i.done;
        word_o[SYNC_POS]      = flags_i.sync;
    end
endmodule

// File: rtl/an_rx_status.sv
module an_rx_status
    import an_rx_pkg::*;
#(
    parameter int unsigned WORD_W   = AN_WORD_W,
    parameter int unsigned CFG_W    = AN_CFG_W,
    parameter int unsigned DONE_POS = AN_DONE_POS,
    parameter int unsigned SYNC_POS = AN_SYNC_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word_i,
    input  logic              link_ok_i,
    input  logic              an_enable_i,
    input  logic              an_restart_i,
    input  logic              sync_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] status_o
);
    logic [CFG_W-1:0] cfg_q;
    an_flags_t        flags_q;

    an_cfg_capture #(.W(CFG_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .word_i(cfg_word_i), .word_o(cfg_q)
    );

    an_flag_logic i_flags (
        .clk(clk), .rst_n(rst_n), .link_ok_i(link_ok_i),
        .an_enable_i(an_enable_i), .an_restart_i(an_restart_i),
        .sync_i(sync_i), .rd_i(rd_i), .flags_o(flags_q)
    );

    an_word_pack #(
        .WORD_W(WORD_W), .CFG_W(CFG_W), .DONE_POS(DONE_POS), .SYNC_POS(SYNC_POS)
    ) i_pack (
        .cfg_i(cfg_q), .flags_i(flags_q), .word_o(status_o)
    );
endmodule

// File: rtl/an_rx_status_chk.sv
module an_rx_status_chk #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned CFG_W    = 16,
    parameter int unsigned DONE_POS = 21,
    parameter int unsigned SYNC_POS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  cfg_word_i,
    input logic              link_ok_i,
    input logic              an_enable_i,
    input logic              an_restart_i,
    input logic              sync_i,
    input logic              rd_i,
    input logic [WORD_W-1:0] status_o
);
    localparam logic [WORD_W-1:0] USED_MASK =
        ((WORD_W'(1) << CFG_W) - WORD_W'(1)) |
        (WORD_W'(1) << DONE_POS) | (WORD_W'(1) << SYNC_POS);

    p_cfg_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_o[CFG_W-1:0] == $past(cfg_word_i));

    p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (an_enable_i && !an_restart_i && link_ok_i) |=> status_o[DONE_POS]);

    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (an_enable_i && !an_restart_i && !link_ok_i) |=> $stable(status_o[DONE_POS]));

    p_done_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_i |=> !status_o[DONE_POS]);

    p_done_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable_i |=> !status_o[DONE_POS]);

    p_sync_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !sync_i) |=> !status_o[SYNC_POS]);

    p_sync_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !$rose(status_o[SYNC_POS]));

    p_sync_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> status_o[SYNC_POS] == $past(sync_i));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~USED_MASK) == '0);

    always_comb begin
        if (!rst_n) a_reset_zero_r8: assert (status_o == '0);
    end
endmodule

bind an_rx_status an_rx_status_chk #(
    .WORD_W(WORD_W), .CFG_W(CFG_W), .DONE_POS(DONE_POS), .SYNC_POS(SYNC_POS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_word_i(cfg_word_i), .link_ok_i(link_ok_i),
    .an_enable_i(an_enable_i), .an_restart_i(an_restart_i), .sync_i(sync_i),
    .rd_i(rd_i), .status_o(status_o)
);

// File: tb/test_an_rx_status.sv
module test_an_rx_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word_i = '0;
    logic        link_ok_i = 1'b0;
    logic        an_enable_i = 1'b0;
    logic        an_restart_i = 1'b0;
    logic        sync_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [31:0] status_o;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done_flag = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    // model state, written from the requirements
    logic [15:0] m_cfg = '0;
    logic        m_done = 1'b0;
    logic        m_sync = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    an_rx_status i_an_rx_status (
        .clk(clk), .rst_n(rst_n), .cfg_word_i(cfg_word_i), .link_ok_i(link_ok_i),
        .an_enable_i(an_enable_i), .an_restart_i(an_restart_i), .sync_i(sync_i),
        .rd_i(rd_i), .status_o(status_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected word
    task automatic step(input logic [15:0] cfg, input logic lok, input logic en,
                        input logic rs, input logic sy, input logic rd, input string tag);
        item_t it;
        @(negedge clk);
        cfg_word_i = cfg; link_ok_i = lok; an_enable_i = en;
        an_restart_i = rs; sync_i = sy; rd_i = rd;
        m_cfg = cfg;
        if (!en || rs) m_done = 1'b0;
        else if (lok)  m_done = 1'b1;
        m_sync = rd ? sy : (m_sync & sy);
        it.exp = {10'b0, m_done, m_sync, 4'b0, m_cfg};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(status_o, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status_o, 32'h0, "R8 reset word");
        rst_n = 1'b1;

        // R8: sync stays low after reset until read, even with live sync high
        step(16'h1234, 0, 1, 0, 1, 0, "R8 sync low before first read");
        step(16'h1234, 0, 1, 0, 1, 0, "R8 sync still low");
        step(16'h1234, 0, 1, 0, 1, 1, "R6 read reloads sync");
        step(16'hA5A5, 0, 1, 0, 1, 0, "R1 cfg follows");
        step(16'h5A5A, 0, 1, 0, 1, 0, "R1 cfg follows");
        // R2: completion sets
        step(16'h01A0, 1, 1, 0, 1, 0, "R2 complete set");
        step(16'h01A0, 0, 1, 0, 1, 0, "R3 complete holds");
        step(16'hFFFF, 0, 1, 0, 1, 0, "R3 hold across cfg change");
        // R5: loss of sync, then recovery, no read
        step(16'hFFFF, 0, 1, 0, 0, 0, "R5 sync drops");
        step(16'hFFFF, 0, 1, 0, 1, 0, "R5 stays low after recovery");
        step(16'hFFFF, 0, 1, 0, 1, 0, "R5 stays low after recovery");
        // R6: read with sync high re-arms; read with sync low keeps low
        step(16'h0F0F, 0, 1, 0, 1, 1, "R6 read re-arms");
        step(16'h0F0F, 0, 1, 0, 0, 1, "R6 read while sync low");
        step(16'h0F0F, 0, 1, 0, 1, 1, "R6 back-to-back read");
        step(16'h0F0F, 0, 1, 0, 1, 0, "R6 after read");
        // R3: restart clears, priority over link_ok
        step(16'h0F0F, 1, 1, 1, 1, 0, "R3 restart beats link_ok");
        step(16'h0F0F, 0, 1, 0, 1, 0, "R3 stays clear");
        step(16'h0F0F, 1, 1, 0, 1, 0, "R2 set again");
        // R4: disable clears and blocks set
        step(16'h0F0F, 1, 0, 0, 1, 0, "R4 disable clears");
        step(16'h0F0F, 1, 0, 0, 1, 0, "R4 link_ok ignored when disabled");
        step(16'h0F0F, 0, 1, 0, 1, 0, "R4 re-enable no set");
        // R7: all-ones config keeps reserved bits zero
        step(16'hFFFF, 1, 1, 0, 1, 1, "R7 reserved zero");
        step(16'hFFFF, 0, 1, 0, 1, 0, "R7 reserved zero");
        step(16'h0000, 0, 1, 0, 1, 0, "R1 cfg zero");
        @(posedge clk); #1;
        @(posedge clk); #1;
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule